// File: doc/BRIEF.md
# SD Command Issue Guard

This block guards command issue in an SD host controller. Software writes a command word made of a 6-bit index, a 2-bit application-command field and a data-transfer flag. If the write is allowed, the guard records the fields and sends a one-cycle start pulse to the command engine. It then keeps a busy flag raised until the engine returns a done strobe. Serialising the command, capturing the response and dividing the card clock all happen outside this block.

The guard also drives a permission flag for changing the card-clock divider. A command that starts drops this flag. Once busy falls, the guard counts a fixed number of card-clock enable pulses and then raises the flag again. Two kinds of command write are refused and raise a sticky error flag: any write made while busy, and a stop-transmission command (index 12) that is marked as a data command with the application field at zero. Only an explicit clear from software lowers the error flag.

Top module: `sd_cmd_issue_guard`

## Requirements
- R1: After reset `cmd_busy`=0, `div_wr_ok`=1, `illegal_err`=0 and `cmd_start`=0.
- R2: An accepted write (`cmd_wr`=1 while idle and not refused) raises `cmd_start` for exactly one cycle after the write edge. In that cycle `start_idx`, `start_app` and `start_data` equal the written fields, and `cmd_busy` is 1 from that cycle onward.
- R3: An accepted write drives `div_wr_ok` to 0 in the following cycle, and `div_wr_ok` stays 0 while `cmd_busy` is 1.
- R4: `seq_done` while busy clears `cmd_busy` in the next cycle. `div_wr_ok` stays 0 at that point.
- R5: After busy falls, `div_wr_ok` becomes 1 in the cycle after the HOLD_CYCLES-th `card_clk_en` pulse (default 8). The count includes no pulses seen while busy and no pulse in the same cycle as `seq_done`.
- R6: A write while `cmd_busy`=1 sets `illegal_err`, produces no `cmd_start` and leaves `cmd_busy` unchanged, unless `seq_done` arrives in the same cycle, in which case busy still falls.
- R7: A write with `cmd_data`=1, `cmd_app`=00 and `cmd_idx`=12 sets `illegal_err`, starts nothing and leaves `div_wr_ok` unchanged. Index 12 with `cmd_data`=0 or a non-zero `cmd_app` is accepted.
- R8: `illegal_err` holds until `err_clr` is pulsed. If a refused write and `err_clr` occur in the same cycle, the flag stays 1.
- R9: An accepted write during the re-open count cancels it. After the new command ends, a full HOLD_CYCLES pulses are needed again.
- R10: `seq_done` while idle has no effect on `cmd_busy` or `div_wr_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_idx | input | 6 | Command index written |
| cmd_app | input | 2 | Application-command field written |
| cmd_data | input | 1 | Data-transfer type bit written |
| err_clr | input | 1 | Software clear of the illegal-access flag |
| seq_done | input | 1 | Command engine done strobe |
| card_clk_en | input | 1 | One pulse per card-clock cycle |
| cmd_start | output | 1 | One-cycle start pulse to the command engine |
| start_idx | output | 6 | Latched command index |
| start_app | output | 2 | Latched application-command field |
| start_data | output | 1 | Latched data-transfer bit |
| cmd_busy | output | 1 | Command sequence in progress |
| div_wr_ok | output | 1 | Card-clock divider may be written |
| illegal_err | output | 1 | Sticky illegal-access error |

## Verification
The hardest cases to reach are those where events collide: a new command accepted partway through the re-open count, a done strobe that arrives together with a card-clock pulse, and a refused write that lands in the same cycle as the error clear. The bench drives each of these collisions on purpose at a chosen negative edge, and counts pulses one at a time so it can check the flag at every count. It also sweeps all 512 command words from idle, so the single refused encoding is checked against every neighbour that must be accepted.

// File: rtl/sdcig_pkg.sv
package sdcig_pkg;
   typedef enum logic [1:0] {
      HOLD_OPEN  = 2'd0,
      HOLD_BLOCK = 2'd1,
      HOLD_COUNT = 2'd2
   } hold_state_t;
endpackage

// File: rtl/sdcig_decode.sv
module sdcig_decode #(
   parameter int IDX_W         = 6,
   parameter int APP_W         = 2,
   parameter int STOP_IDX      = 12,
   parameter bit STOP_GUARD_EN = 1'b1
) (
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [APP_W-1:0] app,
   input  logic             data,
   input  logic             busy,
   output logic             accept,
   output logic             refuse
);
   logic stop_hit;

   generate
      if (STOP_GUARD_EN) begin : g_stop_guard
         assign stop_hit = data && (app == '0) && (idx == IDX_W'(STOP_IDX));
      end else begin : g_no_guard
         assign stop_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      refuse = wr && (busy || stop_hit);
      accept = wr && !refuse;
   end
endmodule

// File: rtl/sdcig_busy.sv
module sdcig_busy #(
   parameter int IDX_W = 6,
   parameter int APP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             done,
   input  logic [IDX_W-1:0] idx,
   input  logic [APP_W-1:0] app,
   input  logic             data,
   output logic             busy,
   output logic             busy_fall,
   output logic             start,
   output logic [IDX_W-1:0] start_idx,
   output logic [APP_W-1:0] start_app,
   output logic             start_data
);
   assign busy_fall = busy && done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         start      <= 1'b0;
         start_idx  <= '0;
         start_app  <= '0;
         start_data <= 1'b0;
      end else begin
         start <= accept;
         if (accept) begin
            busy       <= 1'b1;
            start_idx  <= idx;
            start_app  <= app;
            start_data <= data;
         end else if (busy_fall) begin
            busy <= 1'b0;
         end
      end
   end

   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
   assert_done_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> !busy);
   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && start));
endmodule

// File: rtl/sdcig_hold.sv
module sdcig_hold
   import sdcig_pkg::*;
#(
   parameter int HOLD_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic busy_fall,
   input  logic clk_en,
   output logic div_ok
);
   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

   hold_state_t      state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= HOLD_OPEN;
         cnt    <= '0;
         div_ok <= 1'b1;
      end else if (accept) begin
         state  <= HOLD_BLOCK;
         cnt    <= '0;
         div_ok <= 1'b0;
      end else if (busy_fall) begin
         state <= HOLD_COUNT;
         cnt   <= CNT_W'(HOLD_CYCLES);
      end else if (state == HOLD_COUNT && clk_en) begin
         cnt <= cnt - 1'b1;
         if (cnt == CNT_W'(1)) begin
            state  <= HOLD_OPEN;
            div_ok <= 1'b1;
         end
      end
   end

   assert_reopen_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_ok) |-> $past(clk_en));
   assert_block_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !div_ok);
   assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && state == HOLD_COUNT) |=> (state == HOLD_BLOCK));
endmodule

// File: rtl/sdcig_err.sv
module sdcig_err (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic err
);
   always_ff @(posedge clk) begin
      if (!rst_n)   err <= 1'b0;
      else if (set) err <= 1'b1;
      else if (clr) err <= 1'b0;
   end

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
   assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> err);
endmodule

// File: rtl/sd_cmd_issue_guard.sv
module sd_cmd_issue_guard #(
   parameter int IDX_W         = 6,
   parameter int APP_W         = 2,
   parameter int STOP_IDX      = 12,
   parameter bit STOP_GUARD_EN = 1'b1,
   parameter int HOLD_CYCLES   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [IDX_W-1:0] cmd_idx,
   input  logic [APP_W-1:0] cmd_app,
   input  logic             cmd_data,
   input  logic             err_clr,
   input  logic             seq_done,
   input  logic             card_clk_en,
   output logic             cmd_start,
   output logic [IDX_W-1:0] start_idx,
   output logic [APP_W-1:0] start_app,
   output logic             start_data,
   output logic             cmd_busy,
   output logic             div_wr_ok,
   output logic             illegal_err
);
   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (STOP_IDX >= (1 << IDX_W) || STOP_IDX < 0) begin : g_bad_stop
         $error("STOP_IDX does not fit in IDX_W bits");
      end
   endgenerate

   logic accept;
   logic refuse;
   logic busy_fall;

   sdcig_decode #(
      .IDX_W(IDX_W), .APP_W(APP_W), .STOP_IDX(STOP_IDX), .STOP_GUARD_EN(STOP_GUARD_EN)
   ) u_decode (
      .wr(cmd_wr), .idx(cmd_idx), .app(cmd_app), .data(cmd_data),
      .busy(cmd_busy), .accept(accept), .refuse(refuse)
   );

   sdcig_busy #(.IDX_W(IDX_W), .APP_W(APP_W)) u_busy (
      .clk(clk), .rst_n(rst_n), .accept(accept), .done(seq_done),
      .idx(cmd_idx), .app(cmd_app), .data(cmd_data),
      .busy(cmd_busy), .busy_fall(busy_fall), .start(cmd_start),
      .start_idx(start_idx), .start_app(start_app), .start_data(start_data)
   );

   sdcig_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .accept(accept), .busy_fall(busy_fall),
      .clk_en(card_clk_en), .div_ok(div_wr_ok)
   );

   sdcig_err u_err (
      .clk(clk), .rst_n(rst_n), .set(refuse), .clr(err_clr), .err(illegal_err)
   );

   assert_busy_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_busy) |=> (illegal_err && !cmd_start));
   assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_busy |-> !div_wr_ok);
   assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !cmd_busy && !cmd_wr) |=> (!cmd_busy && $stable(div_wr_ok)));

   generate
      if (STOP_GUARD_EN) begin : g_stop_chk
         assert_stop_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_wr && cmd_data && cmd_app == '0 && cmd_idx == IDX_W'(STOP_IDX))
               |=> (!cmd_start && illegal_err));
      end
   endgenerate
endmodule

// File: tb/sd_cmd_issue_guard_bench.sv
module sd_cmd_issue_guard_bench;
   localparam int HOLD = 8;
   localparam int STOP = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [5:0] cmd_idx = '0;
   logic [1:0] cmd_app = '0;
   logic       cmd_data = 1'b0;
   logic       err_clr = 1'b0;
   logic       seq_done = 1'b0;
   logic       card_clk_en = 1'b0;
   logic       cmd_start;
   logic [5:0] start_idx;
   logic [1:0] start_app;
   logic       start_data;
   logic       cmd_busy;
   logic       div_wr_ok;
   logic       illegal_err;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   sd_cmd_issue_guard #(.HOLD_CYCLES(HOLD), .STOP_IDX(STOP)) u_sd_cmd_issue_guard (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_idx(cmd_idx), .cmd_app(cmd_app),
      .cmd_data(cmd_data), .err_clr(err_clr), .seq_done(seq_done),
      .card_clk_en(card_clk_en), .cmd_start(cmd_start), .start_idx(start_idx),
      .start_app(start_app), .start_data(start_data), .cmd_busy(cmd_busy),
      .div_wr_ok(div_wr_ok), .illegal_err(illegal_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_cmd(input logic [5:0] i, input logic [1:0] a, input logic d);
      cmd_wr = 1'b1; cmd_idx = i; cmd_app = a; cmd_data = d;
      step();
      cmd_wr = 1'b0;
   endtask

   task automatic pulse_en();
      card_clk_en = 1'b1; step(); card_clk_en = 1'b0;
   endtask

   task automatic done_now();
      seq_done = 1'b1; step(); seq_done = 1'b0;
   endtask

   task automatic clear_err();
      err_clr = 1'b1; step(); err_clr = 1'b0;
   endtask

   // count n pulses; check div_wr_ok after each
   task automatic count_to_open(input string req, input int n);
      for (int k = 1; k <= n; k++) begin
         pulse_en();
         chk(req, div_wr_ok, (k == HOLD) ? 1 : 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 busy", cmd_busy, 0);
      chk("R1 div_wr_ok", div_wr_ok, 1);
      chk("R1 err", illegal_err, 0);
      chk("R1 start", cmd_start, 0);

      // R10 done while idle
      done_now();
      chk("R10 busy", cmd_busy, 0);
      chk("R10 div_wr_ok", div_wr_ok, 1);

      // sweep all command words (R2, R3, R4, R5, R7)
      for (int c = 0; c < 512; c++) begin
         logic [5:0] i;
         logic [1:0] a;
         logic       d;
         bit         stop;
         i = c[5:0]; a = c[7:6]; d = c[8];
         stop = d && (a == 2'd0) && (i == 6'(STOP));
         write_cmd(i, a, d);
         chk("R7 err", illegal_err, stop ? 1 : 0);
         chk("R2 start", cmd_start, stop ? 0 : 1);
         chk("R2 busy", cmd_busy, stop ? 0 : 1);
         if (stop) begin
            chk("R7 div_wr_ok kept", div_wr_ok, 1);
            clear_err();
            chk("R8 cleared", illegal_err, 0);
         end else begin
            chk("R2 idx", start_idx, i);
            chk("R2 app", start_app, a);
            chk("R2 data", start_data, d);
            chk("R3 div_wr_ok low", div_wr_ok, 0);
            step();
            chk("R2 one pulse", cmd_start, 0);
            done_now();
            chk("R4 busy low", cmd_busy, 0);
            chk("R4 div still low", div_wr_ok, 0);
            count_to_open("R5 reopen", HOLD);
         end
      end

      // R5: pulses during busy and at done are not counted
      write_cmd(6'd17, 2'd1, 1'b0);
      for (int k = 0; k < 5; k++) pulse_en();
      chk("R3 low while busy", div_wr_ok, 0);
      seq_done = 1'b1; card_clk_en = 1'b1; step();
      seq_done = 1'b0; card_clk_en = 1'b0;
      chk("R5 busy low", cmd_busy, 0);
      count_to_open("R5 full count", HOLD);

      // R6: write while busy
      write_cmd(6'd3, 2'd0, 1'b0);
      write_cmd(6'd5, 2'd2, 1'b1);
      chk("R6 err", illegal_err, 1);
      chk("R6 no start", cmd_start, 0);
      chk("R6 busy kept", cmd_busy, 1);
      chk("R6 fields kept", start_idx, 3);
      // R8 sticky and set beats clear
      step(); step();
      chk("R8 sticky", illegal_err, 1);
      err_clr = 1'b1; write_cmd(6'd9, 2'd0, 1'b0); err_clr = 1'b0;
      chk("R8 set wins", illegal_err, 1);
      clear_err();
      chk("R8 clear", illegal_err, 0);
      // R6: write with done in the same cycle
      seq_done = 1'b1; write_cmd(6'd7, 2'd0, 1'b0); seq_done = 1'b0;
      chk("R6 err with done", illegal_err, 1);
      chk("R6 busy falls", cmd_busy, 0);
      chk("R6 no start with done", cmd_start, 0);
      clear_err();
      count_to_open("R5 after collision", HOLD);

      // R9: restart during count
      write_cmd(6'd12, 2'd0, 1'b0);
      chk("R7 idx12 no data accepted", cmd_busy, 1);
      done_now();
      for (int k = 0; k < 4; k++) pulse_en();
      write_cmd(6'd12, 2'd3, 1'b1);
      chk("R9 accepted", cmd_start, 1);
      chk("R9 div low", div_wr_ok, 0);
      chk("R7 app nonzero ok", illegal_err, 0);
      done_now();
      count_to_open("R9 full recount", HOLD);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule